// File: doc/BRIEF.md
# Circular Bus-Snapshot Trace Buffer

This block is a small on-chip trace store that records snapshots of processor bus activity without ever holding the processor back. Each snapshot holds the address bus, the data bus and a few control lines. The snapshot is taken in a cycle where the selected capture source fires. The source can be a single basic trigger, a combined trigger, the output of a trigger sequencer, or every clock cycle. Eight slots are used as a ring, and a new snapshot replaces the oldest one.

A debug host reads entries through a combinational read port at any time, including while capture goes on. Entry 0 is always the oldest valid snapshot, so a trace is read in chronological order. When capture is qualified by a write to one variable, the newest entry shows the value last written to it, which works as a live watch. An optional stop-when-full mode keeps the first eight snapshots instead of wrapping. A clear input empties the buffer.

Top module: `bus_trace_buffer`

## Requirements
- R1: After reset, `entry_count` is 0, `wr_ptr` is 0 and `rd_valid` is low.
- R2: `cap_src` selects the capture condition: 0 captures when `trig_basic` is high, 1 when `trig_combined` is high, 2 when `trig_seq` is high, and 3 captures on every clock cycle. Triggers that are not selected have no effect.
- R3: While `cap_enable` is low, no capture happens: `wr_ptr`, `entry_count` and every stored entry stay unchanged.
- R4: A capture at a rising clock edge stores the values of `bus_addr`, `bus_data` and `bus_ctrl` present at that edge as one entry.
- R5: Each capture advances `wr_ptr` by one, modulo 8. `entry_count` rises by one per capture and saturates at 8.
- R6: `rd_index` is counted from the oldest valid entry: index 0 is the oldest and index `entry_count`-1 is the newest. Once the ring has wrapped, the oldest entry has been overwritten and the following entry takes index 0.
- R7: When `rd_index` is not below `entry_count`, `rd_valid` is low and `rd_addr`, `rd_data` and `rd_ctrl` read as zero.
- R8: A high `clear` at a clock edge sets `wr_ptr` and `entry_count` to 0. It takes priority over a capture in the same cycle, and that capture is not stored.
- R9: With `stop_when_full` high and `entry_count` at 8, captures are ignored. `wr_ptr`, `entry_count` and all entries stay as they are.
- R10: The read port is combinational and never stalls capture. If a read targets the slot that is written at the next edge, it returns the old contents until that edge, and the new snapshot appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_enable | input | 1 | Capture enable |
| cap_src | input | 2 | Capture source select (0 basic, 1 combined, 2 sequencer, 3 every cycle) |
| stop_when_full | input | 1 | Freeze capture when 8 entries are held |
| clear | input | 1 | Reset the write pointer and the entry count |
| trig_basic | input | 1 | Basic trigger event |
| trig_combined | input | 1 | Combined trigger event |
| trig_seq | input | 1 | Sequencer final-state event |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 16 | Processor data bus |
| bus_ctrl | input | 4 | Processor control lines |
| rd_index | input | 3 | Host read index, relative to the oldest entry |
| rd_addr | output | 16 | Address field of the selected entry |
| rd_data | output | 16 | Data field of the selected entry |
| rd_ctrl | output | 4 | Control field of the selected entry |
| rd_valid | output | 1 | Selected entry holds a snapshot |
| wr_ptr | output | 3 | Slot that the next capture writes |
| entry_count | output | 4 | Number of valid entries (0 to 8) |

## Verification
A wrong pointer or count shows on `wr_ptr` and `entry_count` one edge after the capture or clear that caused it. It also moves every relative read, so the oldest-first read order breaks at once once the ring has wrapped. A wrong slot write or a wrong source selection appears in `rd_addr`, `rd_data` and `rd_ctrl` as soon as the affected index is read. The bench reads one random index on every cycle against its own model, so a fault of this kind is reported within a few cycles. Stop-when-full and clear-priority faults appear on the first capture attempt after the condition holds.

// File: rtl/trace_pkg.sv
package trace_pkg;
   typedef enum logic [1:0] {
      SRC_BASIC     = 2'd0,
      SRC_COMBINED  = 2'd1,
      SRC_SEQUENCER = 2'd2,
      SRC_EVERY     = 2'd3
   } cap_src_e;
endpackage

// File: rtl/trace_capture_sel.sv
module trace_capture_sel #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             enable,
   input  logic [1:0]       src,
   input  logic             clear,
   input  logic             stop_full,
   input  logic [CNT_W-1:0] count,
   input  logic             trig_basic,
   input  logic             trig_combined,
   input  logic             trig_seq,
   output logic             capture
);
   import trace_pkg::*;

   logic hit;
   logic frozen;

   always_comb begin
      unique case (cap_src_e'(src))
         SRC_BASIC:     hit = trig_basic;
         SRC_COMBINED:  hit = trig_combined;
         SRC_SEQUENCER: hit = trig_seq;
         default:       hit = 1'b1;
      endcase
   end

   assign frozen  = stop_full && (count == CNT_W'(DEPTH));
   assign capture = enable && hit && !clear && !frozen;
endmodule

// File: rtl/trace_ptr_ctrl.sv
module trace_ptr_ctrl #(
   parameter int DEPTH = 8,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             capture,
   output logic [IDX_W-1:0] wr_ptr,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         count  <= '0;
      end else if (capture) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (count != FULL) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/trace_store.sv
module trace_store #(
   parameter int DEPTH   = 8,
   parameter int IDX_W   = $clog2(DEPTH),
   parameter int ENTRY_W = 36
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [IDX_W-1:0]   wr_ptr,
   input  logic [ENTRY_W-1:0] wr_entry,
   input  logic [IDX_W-1:0]   rd_slot,
   output logic [ENTRY_W-1:0] rd_entry
);
   logic [ENTRY_W-1:0] slot_view [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
      logic [ENTRY_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              slot_q <= '0;
         else if (capture && wr_ptr == IDX_W'(g)) slot_q <= wr_entry;
      end
      assign slot_view[g] = slot_q;
   end

   // Combinational read: same-cycle write to this slot is seen after the edge.
   assign rd_entry = slot_view[rd_slot];
endmodule

// File: rtl/bus_trace_buffer.sv
module bus_trace_buffer #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CTRL_W = 4,
   parameter int DEPTH  = 8,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int ENTRY_W = ADDR_W + DATA_W + CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_enable,
   input  logic [1:0]        cap_src,
   input  logic              stop_when_full,
   input  logic              clear,
   input  logic              trig_basic,
   input  logic              trig_combined,
   input  logic              trig_seq,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [CTRL_W-1:0] bus_ctrl,
   input  logic [IDX_W-1:0]  rd_index,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CTRL_W-1:0] rd_ctrl,
   output logic              rd_valid,
   output logic [IDX_W-1:0]  wr_ptr,
   output logic [CNT_W-1:0]  entry_count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : gen_bad_depth
      $error("bus_trace_buffer: DEPTH must be a power of two and at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1 || CTRL_W < 1) begin : gen_bad_width
      $error("bus_trace_buffer: field widths must be positive");
   end

   logic               capture;
   logic [ENTRY_W-1:0] wr_entry;
   logic [ENTRY_W-1:0] rd_entry;
   logic [IDX_W-1:0]   rd_slot;
   logic               full;

   trace_capture_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sel (
      .enable        (cap_enable),
      .src           (cap_src),
      .clear         (clear),
      .stop_full     (stop_when_full),
      .count         (entry_count),
      .trig_basic    (trig_basic),
      .trig_combined (trig_combined),
      .trig_seq      (trig_seq),
      .capture       (capture)
   );

   trace_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .capture (capture),
      .wr_ptr  (wr_ptr),
      .count   (entry_count)
   );

   assign wr_entry = {bus_ctrl, bus_addr, bus_data};

   // Oldest entry sits at slot 0 until the ring wraps, then at wr_ptr.
   assign full    = (entry_count == CNT_W'(DEPTH));
   assign rd_slot = full ? (wr_ptr + rd_index) : rd_index;

   trace_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .wr_ptr   (wr_ptr),
      .wr_entry (wr_entry),
      .rd_slot  (rd_slot),
      .rd_entry (rd_entry)
   );

   assign rd_valid = CNT_W'(rd_index) < entry_count;
   assign rd_ctrl  = rd_valid ? rd_entry[ENTRY_W-1 -: CTRL_W]          : '0;
   assign rd_addr  = rd_valid ? rd_entry[DATA_W +: ADDR_W]              : '0;
   assign rd_data  = rd_valid ? rd_entry[DATA_W-1:0]                    : '0;
endmodule

// File: rtl/trace_buffer_checker.sv
module trace_buffer_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CTRL_W = 4,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_enable,
   input logic [1:0]        cap_src,
   input logic              stop_when_full,
   input logic              clear,
   input logic              trig_basic,
   input logic              trig_combined,
   input logic              trig_seq,
   input logic [IDX_W-1:0]  rd_index,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [CTRL_W-1:0] rd_ctrl,
   input logic              rd_valid,
   input logic [IDX_W-1:0]  wr_ptr,
   input logic [CNT_W-1:0]  entry_count
);
   logic sel_hit;
   logic will_cap;

   always_comb begin
      case (cap_src)
         2'd0:    sel_hit = trig_basic;
         2'd1:    sel_hit = trig_combined;
         2'd2:    sel_hit = trig_seq;
         default: sel_hit = 1'b1;
      endcase
   end
   assign will_cap = cap_enable && sel_hit && !clear &&
                     !(stop_when_full && entry_count == CNT_W'(DEPTH));

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CNT_W'(DEPTH));

   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      will_cap |=> wr_ptr == IDX_W'($past(wr_ptr) + 1'b1));

   p_ptr_tracks_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_count < CNT_W'(DEPTH)) |-> (CNT_W'(wr_ptr) == entry_count));

   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (wr_ptr == '0 && entry_count == '0));

   p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_enable && !clear) |=> ($stable(wr_ptr) && $stable(entry_count)));

   p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_when_full && entry_count == CNT_W'(DEPTH) && !clear)
      |=> ($stable(wr_ptr) && entry_count == CNT_W'(DEPTH)));

   p_invalid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_addr == '0 && rd_data == '0 && rd_ctrl == '0));
endmodule

bind bus_trace_buffer trace_buffer_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/bus_trace_buffer_tb.sv
module bus_trace_buffer_tb;
   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cap_enable, stop_when_full, clear;
   logic [1:0]  cap_src;
   logic        trig_basic, trig_combined, trig_seq;
   logic [15:0] bus_addr, bus_data;
   logic [3:0]  bus_ctrl;
   logic [2:0]  rd_index;
   logic [15:0] rd_addr, rd_data;
   logic [3:0]  rd_ctrl;
   logic        rd_valid;
   logic [2:0]  wr_ptr;
   logic [3:0]  entry_count;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Bench model
   logic [15:0] m_a [D];
   logic [15:0] m_d [D];
   logic [3:0]  m_c [D];
   int m_ptr = 0;
   int m_cnt = 0;

   always #5 clk = ~clk;

   bus_trace_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable), .cap_src(cap_src),
      .stop_when_full(stop_when_full), .clear(clear),
      .trig_basic(trig_basic), .trig_combined(trig_combined), .trig_seq(trig_seq),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
      .rd_index(rd_index), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ctrl(rd_ctrl),
      .rd_valid(rd_valid), .wr_ptr(wr_ptr), .entry_count(entry_count)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int slot_of(int idx);
      return (m_cnt == D) ? (m_ptr + idx) % D : idx;
   endfunction

   function automatic bit sel_hit();
      case (cap_src)
         2'd0:    return trig_basic;
         2'd1:    return trig_combined;
         2'd2:    return trig_seq;
         default: return 1'b1;
      endcase
   endfunction

   // Called at a negedge with inputs set: checks pre-edge outputs, advances model, steps one clock.
   task automatic cycle(string tag);
      int idx, s;
      bit exp_v, cap;
      #1;
      idx   = int'(rd_index);
      exp_v = idx < m_cnt;
      s     = slot_of(idx);
      chk(tag, "wr_ptr", int'(wr_ptr), m_ptr);
      chk(tag, "entry_count", int'(entry_count), m_cnt);
      chk(tag, "rd_valid", int'(rd_valid), int'(exp_v));
      chk(tag, "rd_addr", int'(rd_addr), exp_v ? int'(m_a[s]) : 0);
      chk(tag, "rd_data", int'(rd_data), exp_v ? int'(m_d[s]) : 0);
      chk(tag, "rd_ctrl", int'(rd_ctrl), exp_v ? int'(m_c[s]) : 0);
      cap = cap_enable && sel_hit() && !(stop_when_full && m_cnt == D);
      if (clear) begin
         m_ptr = 0; m_cnt = 0;
      end else if (cap) begin
         m_a[m_ptr] = bus_addr; m_d[m_ptr] = bus_data; m_c[m_ptr] = bus_ctrl;
         m_ptr = (m_ptr + 1) % D;
         if (m_cnt < D) m_cnt++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rand_bus();
      bus_addr = 16'($urandom);
      bus_data = 16'($urandom);
      bus_ctrl = 4'($urandom);
   endtask

   task automatic idle_inputs();
      cap_enable = 0; cap_src = 2'd0; stop_when_full = 0; clear = 0;
      trig_basic = 0; trig_combined = 0; trig_seq = 0;
      bus_addr = 0; bus_data = 0; bus_ctrl = 0; rd_index = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < D; i++) begin m_a[i] = 0; m_d[i] = 0; m_c[i] = 0; end
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      cycle("R1");

      // R3: enable low, every trigger high, source every-cycle
      cap_src = 2'd3; trig_basic = 1; trig_combined = 1; trig_seq = 1;
      for (int i = 0; i < 4; i++) begin rand_bus(); cycle("R3"); end

      // R2: each source, selected trigger toggled, others held opposite
      cap_enable = 1;
      for (int s = 0; s < 4; s++) begin
         cap_src = 2'(s);
         for (int k = 0; k < 4; k++) begin
            bit t;
            t = k[0];
            trig_basic    = (s == 0) ? t : !t;
            trig_combined = (s == 1) ? t : !t;
            trig_seq      = (s == 2) ? t : !t;
            rand_bus();
            rd_index = 3'(k);
            cycle("R2");
         end
      end

      // R8: clear with a capture pending in the same cycle
      cap_src = 2'd3; clear = 1; rand_bus(); cycle("R8");
      clear = 0;
      // R7: read beyond the count after clear
      cap_enable = 0; rd_index = 3'd5; cycle("R7");
      cap_enable = 1;

      // R5 R6: fill past eight with every-cycle capture, read each index
      for (int i = 0; i < 13; i++) begin
         rand_bus(); rd_index = 3'(i); cycle("R5 R6");
      end
      cap_enable = 0;
      for (int i = 0; i < D; i++) begin rd_index = 3'(i); cycle("R6"); end

      // R10: read the oldest slot while it is overwritten
      cap_enable = 1; rd_index = 3'd0; rand_bus(); cycle("R10");
      cap_enable = 0; rd_index = 3'd7; cycle("R10");

      // R9: stop-when-full after a clear
      clear = 1; cycle("R9"); clear = 0;
      cap_enable = 1; stop_when_full = 1;
      for (int i = 0; i < 12; i++) begin
         rand_bus(); rd_index = 3'(i); cycle("R9");
      end
      stop_when_full = 0;

      // R4 R6: constrained random traffic
      for (int i = 0; i < 600; i++) begin
         cap_enable     = ($urandom % 8) != 0;
         cap_src        = 2'($urandom);
         stop_when_full = (i / 150) % 2 == 1;
         clear          = ($urandom % 40) == 0;
         trig_basic     = 1'($urandom);
         trig_combined  = 1'($urandom);
         trig_seq       = 1'($urandom);
         rd_index       = 3'($urandom);
         rand_bus();
         cycle("R4 R6");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule